// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This unit carries out the bit-manipulation group of an 8-bit processor datapath. It covers circular rotates, rotates through the carry, shifts to the left, arithmetic shifts to the right, logical shifts to the right, a nibble swap, a single-bit test, a single-bit clear and a single-bit set. The surrounding datapath fetches the operand and supplies the incoming carry, a bit index and an operation code. It then takes back the result, a write-back enable, the new flag values and a per-flag update mask. Operand fetch and write-back stay outside the unit.

Each operation is computed combinationally. It is then captured in one output register stage, so every result appears one clock edge after its inputs are sampled. A separate short-form input marks the accumulator-only rotate encodings. For those encodings the zero flag is forced low instead of being derived from the result.

Top module: `bitops_unit`

## Requirements
- R1: Operation codes are fixed as follows. 0 is circular rotate left and 1 is circular rotate right. For these two, the bit shifted out goes both into the vacated end and into C.
- R2: Codes 2 (rotate left through carry) and 3 (rotate right through carry) insert the incoming carry at the vacated end. The bit shifted out becomes C.
- R3: Codes 0 to 7 update all four flags, so flag_wr is 4'b1111. They always clear N and H. Without the short form, Z is 1 exactly when the result is zero. The flag bit order in `flags` and `flag_wr` is [3]=Z, [2]=N, [1]=H, [0]=C.
- R4: When short_form is 1 with codes 0 to 3, Z is forced to 0 whatever the result. For codes 4 to 15, short_form has no effect.
- R5: Code 4 shifts left with a 0 fill and puts bit 7 into C. Code 5 shifts right, keeps bit 7 and puts bit 0 into C. Code 6 shifts right with a 0 fill and puts bit 0 into C.
- R6: Code 7 exchanges the two nibbles, clears C and sets Z from the result.
- R7: Code 8 tests bit `bit_idx` of the operand. Z becomes the inverse of that bit, N becomes 0 and H becomes 1. C is not updated, so flag_wr is 4'b1110, and the C output repeats carry_in. wr_en is 0 and the result equals the operand.
- R8: Code 9 clears bit `bit_idx` and code 10 sets it. Both give wr_en=1 and flag_wr=4'b0000.
- R9: Codes 11 to 15 give result 0, wr_en=0 and flag_wr=4'b0000. For any flag that is not updated, the Z, N and H outputs are 0 and the C output equals carry_in.
- R10: All outputs are registered and follow their inputs one rising clock edge later. An active-low asynchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 4 | Operation code (R1 to R9) |
| short_form | input | 1 | Accumulator-only rotate encoding |
| operand | input | 8 | Value to operate on |
| carry_in | input | 1 | Incoming carry flag |
| bit_idx | input | 3 | Bit index for test, clear and set |
| result | output | 8 | Operation result |
| wr_en | output | 1 | Result must be written back |
| flags | output | 4 | New flag values {Z,N,H,C} |
| flag_wr | output | 4 | Per-flag update mask {Z,N,H,C} |

## Verification
Every output (result, wr_en, flags and flag_wr) is due exactly one rising edge after the operation code and operand are presented. The only exception is reset, which clears the outputs at once without waiting for a clock edge. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so exactly one capture edge lies between stimulus and check. A directed test also reads the outputs before that edge and confirms they still hold the previous operation. A second directed test asserts reset between edges and confirms the outputs clear without a clock.

// File: rtl/bitops_pkg.sv
package bitops_pkg;

    typedef enum logic [3:0] {
        OP_RLC  = 4'd0,
        OP_RRC  = 4'd1,
        OP_RL   = 4'd2,
        OP_RR   = 4'd3,
        OP_SLA  = 4'd4,
        OP_SRA  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SWAP = 4'd7,
        OP_BIT  = 4'd8,
        OP_RES  = 4'd9,
        OP_SET  = 4'd10
    } bop_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    localparam logic [3:0] FWR_ALL  = 4'b1111;
    localparam logic [3:0] FWR_TEST = 4'b1110;
    localparam logic [3:0] FWR_NONE = 4'b0000;

endpackage

// File: rtl/bitops_shift.sv
module bitops_shift
    import bitops_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bop_e              op,
    input  logic [DATA_W-1:0] opnd,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              hit
);
    localparam int HALF = DATA_W / 2;

    logic msb;
    logic lsb;

    assign msb = opnd[DATA_W-1];
    assign lsb = opnd[0];

    always_comb begin
        res  = '0;
        cout = 1'b0;
        hit  = 1'b1;
        case (op)
            OP_RLC: begin
                res  = {opnd[DATA_W-2:0], msb};
                cout = msb;
            end
            OP_RRC: begin
                res  = {lsb, opnd[DATA_W-1:1]};
                cout = lsb;
            end
            OP_RL: begin
                res  = {opnd[DATA_W-2:0], cin};
                cout = msb;
            end
            OP_RR: begin
                res  = {cin, opnd[DATA_W-1:1]};
                cout = lsb;
            end
            OP_SLA: begin
                res  = {opnd[DATA_W-2:0], 1'b0};
                cout = msb;
            end
            OP_SRA: begin
                res  = {msb, opnd[DATA_W-1:1]};
                cout = lsb;
            end
            OP_SRL: begin
                res  = {1'b0, opnd[DATA_W-1:1]};
                cout = lsb;
            end
            OP_SWAP: begin
                res  = {opnd[HALF-1:0], opnd[DATA_W-1:HALF]};
                cout = 1'b0;
            end
            default: begin
                hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bitops_bitfield.sv
module bitops_bitfield #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [IDX_W-1:0]  idx,
    output logic              sel_bit,
    output logic [DATA_W-1:0] cleared,
    output logic [DATA_W-1:0] setv
);
    logic [DATA_W-1:0] mask;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign mask[gi] = (idx == IDX_W'(gi));
    end

    assign sel_bit = |(opnd & mask);
    assign cleared = opnd & ~mask;
    assign setv    = opnd | mask;
endmodule

// File: rtl/bitops_unit.sv
module bitops_unit
    import bitops_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_sel,
    input  logic              short_form,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [3:0]        flags,
    output logic [3:0]        flag_wr
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        flags_t            fl;
        logic [3:0]        fwr;
    } out_t;

    bop_e              op;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic              sh_hit;
    logic              bf_bit;
    logic [DATA_W-1:0] bf_clr;
    logic [DATA_W-1:0] bf_set;
    logic              is_rot;
    out_t              st_d;
    out_t              st_q;

    assign op     = bop_e'(op_sel);
    assign is_rot = (op_sel <= 4'd3);

    bitops_shift #(.DATA_W(DATA_W)) u_shift (
        .op   (op),
        .opnd (operand),
        .cin  (carry_in),
        .res  (sh_res),
        .cout (sh_c),
        .hit  (sh_hit)
    );

    bitops_bitfield #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_field (
        .opnd    (operand),
        .idx     (bit_idx),
        .sel_bit (bf_bit),
        .cleared (bf_clr),
        .setv    (bf_set)
    );

    always_comb begin
        st_d      = '0;
        st_d.fl.c = carry_in;
        if (sh_hit) begin
            st_d.res  = sh_res;
            st_d.we   = 1'b1;
            st_d.fl.z = (short_form && is_rot) ? 1'b0 : ~|sh_res;
            st_d.fl.n = 1'b0;
            st_d.fl.h = 1'b0;
            st_d.fl.c = sh_c;
            st_d.fwr  = FWR_ALL;
        end else begin
            case (op)
                OP_BIT: begin
                    st_d.res  = operand;
                    st_d.fl.z = ~bf_bit;
                    st_d.fl.h = 1'b1;
                    st_d.fwr  = FWR_TEST;
                end
                OP_RES: begin
                    st_d.res = bf_clr;
                    st_d.we  = 1'b1;
                    st_d.fwr = FWR_NONE;
                end
                OP_SET: begin
                    st_d.res = bf_set;
                    st_d.we  = 1'b1;
                    st_d.fwr = FWR_NONE;
                end
                default: begin
                    st_d.fwr = FWR_NONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result  = st_q.res;
    assign wr_en   = st_q.we;
    assign flags   = st_q.fl;
    assign flag_wr = st_q.fwr;
endmodule

// File: rtl/bitops_unit_chk.sv
module bitops_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_sel,
    input logic       short_form,
    input logic       wr_en,
    input logic [3:0] flags,
    input logic [3:0] flag_wr
);
    p_rotshift_nh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel <= 4'd7) |=> (flags[2:1] == 2'b00 && flag_wr == 4'b1111 && wr_en));

    p_short_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (short_form && op_sel <= 4'd3) |=> !flags[3]);

    p_swap_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd7) |=> !flags[0]);

    p_test_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd8) |=> (!wr_en && flags[2:1] == 2'b01 && flag_wr == 4'b1110));

    p_field_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd9 || op_sel == 4'd10) |=> (wr_en && flag_wr == 4'b0000));

    p_unused_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd10) |=> (!wr_en && flag_wr == 4'b0000));
endmodule

bind bitops_unit bitops_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_sel     (op_sel),
    .short_form (short_form),
    .wr_en      (wr_en),
    .flags      (flags),
    .flag_wr    (flag_wr)
);

// File: tb/bitops_unit_tb.sv
module bitops_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic       short_form = 1'b0;
    logic [7:0] operand = '0;
    logic       carry_in = 1'b0;
    logic [2:0] bit_idx = '0;
    logic [7:0] result;
    logic       wr_en;
    logic [3:0] flags;
    logic [3:0] flag_wr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bitops_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .short_form(short_form),
        .operand(operand), .carry_in(carry_in), .bit_idx(bit_idx),
        .result(result), .wr_en(wr_en), .flags(flags), .flag_wr(flag_wr)
    );

    // {op, short, operand, cin, idx, exp_res, exp_we, exp_flags, exp_fwr}
    localparam int NV = 20;
    localparam logic [33:0] VEC [NV] = '{
        {4'd0, 1'b0, 8'h85, 1'b0, 3'd0, 8'h0B, 1'b1, 4'b0001, 4'hF}, // R1
        {4'd1, 1'b0, 8'h01, 1'b0, 3'd0, 8'h80, 1'b1, 4'b0001, 4'hF}, // R1
        {4'd2, 1'b0, 8'h80, 1'b0, 3'd0, 8'h00, 1'b1, 4'b1001, 4'hF}, // R2 R3
        {4'd2, 1'b1, 8'h80, 1'b0, 3'd0, 8'h00, 1'b1, 4'b0001, 4'hF}, // R4
        {4'd3, 1'b0, 8'h01, 1'b1, 3'd0, 8'h80, 1'b1, 4'b0001, 4'hF}, // R2
        {4'd1, 1'b1, 8'h00, 1'b1, 3'd0, 8'h00, 1'b1, 4'b0000, 4'hF}, // R4
        {4'd4, 1'b0, 8'hC1, 1'b1, 3'd0, 8'h82, 1'b1, 4'b0001, 4'hF}, // R5
        {4'd5, 1'b0, 8'h81, 1'b0, 3'd0, 8'hC0, 1'b1, 4'b0001, 4'hF}, // R5
        {4'd6, 1'b0, 8'h81, 1'b0, 3'd0, 8'h40, 1'b1, 4'b0001, 4'hF}, // R5
        {4'd6, 1'b0, 8'h01, 1'b0, 3'd0, 8'h00, 1'b1, 4'b1001, 4'hF}, // R5 R3
        {4'd7, 1'b0, 8'hA5, 1'b1, 3'd0, 8'h5A, 1'b1, 4'b0000, 4'hF}, // R6
        {4'd7, 1'b0, 8'h00, 1'b1, 3'd0, 8'h00, 1'b1, 4'b1000, 4'hF}, // R6
        {4'd8, 1'b0, 8'hF7, 1'b1, 3'd3, 8'hF7, 1'b0, 4'b1011, 4'hE}, // R7
        {4'd8, 1'b0, 8'h80, 1'b0, 3'd7, 8'h80, 1'b0, 4'b0010, 4'hE}, // R7
        {4'd9, 1'b0, 8'hFF, 1'b1, 3'd0, 8'hFE, 1'b1, 4'b0001, 4'h0}, // R8
        {4'd10,1'b0, 8'h00, 1'b0, 3'd6, 8'h40, 1'b1, 4'b0000, 4'h0}, // R8
        {4'd4, 1'b1, 8'h80, 1'b0, 3'd0, 8'h00, 1'b1, 4'b1001, 4'hF}, // R4 short ignored
        {4'd11,1'b0, 8'h55, 1'b1, 3'd2, 8'h00, 1'b0, 4'b0001, 4'h0}, // R9
        {4'd2, 1'b0, 8'h40, 1'b1, 3'd0, 8'h81, 1'b1, 4'b0000, 4'hF}, // R2
        {4'd3, 1'b1, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1, 4'b0000, 4'hF}  // R4
    };

    localparam int REQ [NV] = '{1,1,2,4,2,4,5,5,5,5,6,6,7,7,8,8,4,9,2,4};

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] outs();
        return {result, wr_en, flags, flag_wr};
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset state", outs(), 17'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {op_sel, short_form, operand, carry_in, bit_idx} = VEC[i][33:17];
            @(negedge clk);
            check($sformatf("R%0d vector %0d", REQ[i], i), outs(), VEC[i][16:0]);
        end

        // R10: output holds until the next rising edge
        @(negedge clk);
        op_sel = 4'd7; short_form = 1'b0; operand = 8'h12; carry_in = 1'b0;
        #1;
        check("R10 before edge", outs(), {8'h00, 1'b1, 4'b0000, 4'hF});
        @(negedge clk);
        check("R10 after edge", outs(), {8'h21, 1'b1, 4'b0000, 4'hF});

        // R8: set on an already-set bit keeps value, clear on cleared bit
        op_sel = 4'd10; operand = 8'h81; bit_idx = 3'd7; carry_in = 1'b0;
        @(negedge clk);
        check("R8 set idempotent", outs(), {8'h81, 1'b1, 4'b0000, 4'h0});
        op_sel = 4'd9; operand = 8'h7E; bit_idx = 3'd0;
        @(negedge clk);
        check("R8 clear idempotent", outs(), {8'h7E, 1'b1, 4'b0000, 4'h0});

        // R1: circular rotate of all ones
        op_sel = 4'd0; operand = 8'hFF; carry_in = 1'b0;
        @(negedge clk);
        check("R1 rotate all ones", outs(), {8'hFF, 1'b1, 4'b0001, 4'hF});

        // R9: top unused code
        op_sel = 4'd15; operand = 8'hFF; carry_in = 1'b0;
        @(negedge clk);
        check("R9 code 15", outs(), {8'h00, 1'b0, 4'b0000, 4'h0});

        // R10: asynchronous reset between edges
        op_sel = 4'd10; operand = 8'h00; bit_idx = 3'd1;
        @(negedge clk);
        #0.5 rst_n = 1'b0;
        #0.5;
        check("R10 async reset", outs(), 17'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule